// File: doc/BRIEF.md
# Multichannel DAC FIFO Sequencer

This block feeds a bank of DAC channels from one sample queue. A host loads preformatted 16-bit codes (left-justified, offset binary for bipolar ranges) into the queue through a small 16-bit register window. Each trigger then sends one sample to every enabled channel. Channels are served in ascending channel number on consecutive clock cycles, and the block emits a channel number, the code and a one-cycle load strobe for each channel.

The trigger may come from a host read of the data address, from either edge of an external input, or from the rising edge of one of three pacer outputs. The host can read back the configuration, a coarse fill code, a busy flag and a sticky underrun flag. A selectable queue condition drives the interrupt line. In recirculating mode every sample sent out is appended again at the tail, so a loaded waveform repeats without further host traffic. The polarity and reference fields are kept for the analog side and do not alter the codes.

Top module: `dacseq`

## Requirements
- R1: The queue holds DEPTH words (4096 by default). A write to address 0 appends `bus_wdata` only when the enable bit (control bit 8) is 1 and the queue is not full. Other such writes are dropped.
- R2: Control bits 2:0 pick the trigger. 0 and 7 mean no trigger. 1 means a host read of address 0. 2 is a rising edge of `ext_trig` and 3 a falling edge. 4, 5 and 6 are a rising edge of `pacer_out[0]`, `[1]` and `[2]`. With the enable bit at 0 all triggers are ignored.
- R3: An accepted trigger pops one word per enabled channel, in queue order. It raises `dac_load` for one cycle per channel on consecutive cycles, in ascending `dac_chan` order, with `dac_code` equal to the stored word. The first load follows the second clock edge after the trigger.
- R4: Status bit 15 (busy) is 1 from the edge that accepts a trigger up to the edge of the last load. Triggers that arrive while busy are ignored.
- R5: A trigger that finds fewer words than enabled channels, with a nonzero mask, loads nothing and leaves the queue unchanged. It sets status bit 6, which stays set until a queue reset or a global reset.
- R6: With control bit 7 set, each word sent out is appended again at the tail. The count does not change and the sequence repeats.
- R7: Status bits 14:12 give the fill code: 001 empty, 000 for 1 to DEPTH/2-1 words, 100 for DEPTH/2 to DEPTH-1 words, 110 full.
- R8: Control bits 11:9 select what drives `fifo_irq` high: 0 empty, 1 not empty, 2 below DEPTH/2, 3 at least DEPTH/2, 4 not full, 5 full. 6 and 7 keep it low.
- R9: A control write with bit 12 set empties the queue, clears the underrun flag and aborts a scan. The other configuration bits of that write are stored. Bits 12 and 13 are never stored. Control bits 11:7 and 5:0 read back as written.
- R10: A control write with bit 13 set clears the configuration, the channel mask, the queue and the underrun flag. The rest of that write is ignored.
- R11: Address 6 holds the channel-enable mask, one bit per channel starting at bit 0, and reads back. A scan uses the mask captured when its trigger was accepted.
- R12: The polarity bit (3) and the reference field (5:4) are stored only. Output codes are the same for every setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 3 | Byte address: 0 data, 2 control/status, 6 channel mask |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (read of address 0 is the software trigger) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| ext_trig | input | 1 | External trigger input |
| pacer_out | input | 3 | Pacer counter outputs |
| dac_chan | output | $clog2(NCH) | Channel being loaded |
| dac_code | output | 16 | Code for that channel |
| dac_load | output | 1 | One-cycle load strobe |
| fifo_irq | output | 1 | Selected queue condition |

## Verification
A wrong pointer or count in the queue shows up at the first scan as a wrong `dac_code` or a wrong fill code on the next status read, a few cycles after the fault. A fault in the channel walk shows up as a skipped, repeated or out-of-order `dac_chan` within the same burst of loads, and a wrong busy span shows up as extra loads from a second trigger. Sweeping every interrupt select against every fill count of a small queue exposes any threshold error on the `fifo_irq` pin at once.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;

  typedef enum logic [2:0] {
    TRG_NONE     = 3'd0,
    TRG_SOFT     = 3'd1,
    TRG_EXT_RISE = 3'd2,
    TRG_EXT_FALL = 3'd3,
    TRG_PACE0    = 3'd4,
    TRG_PACE1    = 3'd5,
    TRG_PACE2    = 3'd6,
    TRG_SPARE    = 3'd7
  } trig_sel_e;

  localparam logic [2:0] ADDR_DATA = 3'd0;
  localparam logic [2:0] ADDR_CTRL = 3'd2;
  localparam logic [2:0] ADDR_MASK = 3'd6;

  localparam int BIT_WRAP   = 7;
  localparam int BIT_EN     = 8;
  localparam int BIT_FCLR   = 12;
  localparam int BIT_GCLR   = 13;

  // Coarse occupancy code reported in status bits 14:12.
  function automatic logic [2:0] fill_code(input int unsigned cnt, input int unsigned depth);
    if (cnt == 0) return 3'b001;
    if (cnt >= depth) return 3'b110;
    if (cnt >= depth / 2) return 3'b100;
    return 3'b000;
  endfunction

  // Interrupt condition selected by control bits 11:9.
  function automatic logic irq_hit(input logic [2:0] sel, input int unsigned cnt,
                                   input int unsigned depth);
    case (sel)
      3'd0:    return cnt == 0;
      3'd1:    return cnt != 0;
      3'd2:    return cnt < depth / 2;
      3'd3:    return cnt >= depth / 2;
      3'd4:    return cnt < depth;
      3'd5:    return cnt >= depth;
      default: return 1'b0;
    endcase
  endfunction

  // Lowest set bit of m at or above position 'from'; 16 when none.
  function automatic int first_set_from(input logic [15:0] m, input int from);
    int r;
    r = 16;
    for (int i = 15; i >= 0; i--) begin
      if (m[i] && i >= from) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/dacseq_fifo.sv
module dacseq_fifo #(
  parameter int DEPTH = 4096,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [15:0]      push_word,
  input  logic             pop,
  input  logic             wrap,
  output logic [15:0]      head_word,
  output logic [CNT_W-1:0] count
);

  logic [15:0]      mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count_q;
  logic             recirc, push_ok, take;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign recirc    = pop && wrap;
  assign push_ok   = push && !recirc && (count_q != CNT_W'(DEPTH));
  assign take      = pop && !wrap;
  assign head_word = mem[rd_ptr];
  assign count     = count_q;

  always_ff @(posedge clk) begin
    if (recirc) mem[wr_ptr] <= mem[rd_ptr];
    else if (push_ok) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else if (clr) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (recirc || push_ok) wr_ptr <= bump(wr_ptr);
      if (pop) rd_ptr <= bump(rd_ptr);
      if (push_ok && !take) count_q <= count_q + 1'b1;
      else if (take && !push_ok) count_q <= count_q - 1'b1;
    end
  end

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));
  assert_no_pop_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count_q != '0);
  assert_wrap_keeps_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && wrap && !clr) |=> count_q == $past(count_q));
  assert_full_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == CNT_W'(DEPTH) && push && !pop && !clr) |=> count_q == CNT_W'(DEPTH));

endmodule

// File: rtl/dacseq_trig.sv
module dacseq_trig
  import dacseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       sw_req,
  input  logic       ext_in,
  input  logic [2:0] pace_in,
  output logic       fire
);

  logic       ext_q;
  logic [2:0] pace_q;
  logic [2:0] pace_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q  <= 1'b0;
      pace_q <= '0;
    end else begin
      ext_q  <= ext_in;
      pace_q <= pace_in;
    end
  end

  assign pace_rise = pace_in & ~pace_q;

  always_comb begin
    case (trig_sel_e'(sel))
      TRG_SOFT:     fire = sw_req;
      TRG_EXT_RISE: fire = ext_in && !ext_q;
      TRG_EXT_FALL: fire = !ext_in && ext_q;
      TRG_PACE0:    fire = pace_rise[0];
      TRG_PACE1:    fire = pace_rise[1];
      TRG_PACE2:    fire = pace_rise[2];
      default:      fire = 1'b0;
    endcase
  end

  assert_fire_has_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (sel != TRG_NONE && sel != TRG_SPARE));

endmodule

// File: rtl/dacseq_scan.sv
module dacseq_scan
  import dacseq_pkg::*;
#(
  parameter int NCH  = 16,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            abort,
  input  logic            start,
  input  logic [NCH-1:0]  mask_in,
  input  logic [15:0]     head_word,
  output logic            busy,
  output logic            pop,
  output logic            load,
  output logic [CH_W-1:0] chan,
  output logic [15:0]     code
);

  logic            busy_q, load_q;
  logic [NCH-1:0]  live_q;
  logic [CH_W-1:0] ptr_q, chan_q;
  logic [15:0]     code_q;
  int              first_en, nxt;

  always_comb begin
    first_en = first_set_from(16'(mask_in), 0);
    nxt      = first_set_from(16'(live_q), int'(ptr_q) + 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      load_q <= 1'b0;
      live_q <= '0;
      ptr_q  <= '0;
      chan_q <= '0;
      code_q <= '0;
    end else if (abort) begin
      busy_q <= 1'b0;
      load_q <= 1'b0;
    end else begin
      load_q <= 1'b0;
      if (busy_q) begin
        load_q <= 1'b1;
        chan_q <= ptr_q;
        code_q <= head_word;
        if (nxt >= NCH) busy_q <= 1'b0;
        else ptr_q <= CH_W'(nxt);
      end else if (start) begin
        busy_q <= 1'b1;
        live_q <= mask_in;
        ptr_q  <= CH_W'(first_en);
      end
    end
  end

  assign busy = busy_q;
  assign pop  = busy_q && !abort;
  assign load = load_q;
  assign chan = chan_q;
  assign code = code_q;

  assert_start_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
  assert_load_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_q) |-> $past(busy_q));
  assert_ascending_chan_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_q && $past(load_q)) |-> chan_q > $past(chan_q));

endmodule

// File: rtl/dacseq.sv
module dacseq
  import dacseq_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int DEPTH = 4096,
  localparam int CH_W  = $clog2(NCH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [15:0]     bus_wdata,
  output logic [15:0]     bus_rdata,
  input  logic            ext_trig,
  input  logic [2:0]      pacer_out,
  output logic [CH_W-1:0] dac_chan,
  output logic [15:0]     dac_code,
  output logic            dac_load,
  output logic            fifo_irq
);

  logic [11:0]      cfg_q;
  logic [NCH-1:0]   mask_q;
  logic             under_q;
  logic             wr_data, wr_ctrl, wr_mask, sw_req;
  logic             gclr, fclr;
  logic             fire, go, start, short_go, busy, pop;
  logic [15:0]      head_word;
  logic [CNT_W-1:0] count;
  int unsigned      n_en;

  assign wr_data = bus_wr && bus_addr == ADDR_DATA;
  assign wr_ctrl = bus_wr && bus_addr == ADDR_CTRL;
  assign wr_mask = bus_wr && bus_addr == ADDR_MASK;
  assign sw_req  = bus_rd && bus_addr == ADDR_DATA;
  assign gclr    = wr_ctrl && bus_wdata[BIT_GCLR];
  assign fclr    = gclr || (wr_ctrl && bus_wdata[BIT_FCLR]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      mask_q  <= '0;
      under_q <= 1'b0;
    end else if (gclr) begin
      cfg_q   <= '0;
      mask_q  <= '0;
      under_q <= 1'b0;
    end else begin
      if (wr_ctrl) cfg_q <= bus_wdata[11:0] & 12'hFBF;
      if (wr_mask) mask_q <= bus_wdata[NCH-1:0];
      if (fclr) under_q <= 1'b0;
      else if (short_go) under_q <= 1'b1;
    end
  end

  dacseq_trig u_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (cfg_q[2:0]),
    .sw_req  (sw_req),
    .ext_in  (ext_trig),
    .pace_in (pacer_out),
    .fire    (fire)
  );

  assign n_en     = $countones(mask_q);
  assign go       = fire && !busy && cfg_q[BIT_EN] && (mask_q != '0) && !fclr;
  assign start    = go && (32'(count) >= n_en);
  assign short_go = go && (32'(count) < n_en);

  dacseq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (fclr),
    .push      (wr_data && cfg_q[BIT_EN]),
    .push_word (bus_wdata),
    .pop       (pop),
    .wrap      (cfg_q[BIT_WRAP]),
    .head_word (head_word),
    .count     (count)
  );

  dacseq_scan #(.NCH(NCH)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (fclr),
    .start     (start),
    .mask_in   (mask_q),
    .head_word (head_word),
    .busy      (busy),
    .pop       (pop),
    .load      (dac_load),
    .chan      (dac_chan),
    .code      (dac_code)
  );

  always_comb begin
    case (bus_addr)
      ADDR_CTRL: bus_rdata = {busy, fill_code(32'(count), DEPTH), cfg_q[11:7], under_q, cfg_q[5:0]};
      ADDR_MASK: bus_rdata = 16'(mask_q);
      default:   bus_rdata = '0;
    endcase
  end

  assign fifo_irq = irq_hit(cfg_q[11:9], 32'(count), DEPTH);

  assert_short_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    short_go |=> under_q);
  assert_short_no_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (short_go && !busy) |=> !busy);
  assert_gclr_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    gclr |=> (count == '0 && mask_q == '0));

endmodule

// File: tb/dacseq_bench.sv
`timescale 1ns/1ps
module dacseq_bench;
  localparam int NCH = 4;
  localparam int DEP = 16;

  logic        clk = 0, rst_n = 0;
  logic [2:0]  bus_addr = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic        ext_trig = 0;
  logic [2:0]  pacer_out = 0;
  logic [1:0]  dac_chan;
  logic [15:0] dac_code;
  logic        dac_load, fifo_irq;

  int checks = 0, errors = 0, cyc = 0, lcnt = 0;
  int ld_ch [64];
  int ld_code [64];
  int ld_cyc [64];

  always #2 clk = ~clk;

  dacseq #(.NCH(NCH), .DEPTH(DEP)) u_dacseq (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_trig(ext_trig),
    .pacer_out(pacer_out), .dac_chan(dac_chan), .dac_code(dac_code),
    .dac_load(dac_load), .fifo_irq(fifo_irq));

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (dac_load && lcnt < 64) begin
      ld_ch[lcnt]   <= int'(dac_chan);
      ld_code[lcnt] <= int'(dac_code);
      ld_cyc[lcnt]  <= cyc;
      lcnt          <= lcnt + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_fill(input int n);
    if (n == 0) return 1;
    if (n >= DEP) return 6;
    if (n >= DEP / 2) return 4;
    return 0;
  endfunction

  function automatic int exp_irq(input int sel, input int n);
    case (sel)
      0: return int'(n == 0);
      1: return int'(n != 0);
      2: return int'(n < DEP / 2);
      3: return int'(n >= DEP / 2);
      4: return int'(n < DEP);
      5: return int'(n == DEP);
      default: return 0;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);

    // Reset state
    rd(3'd2, v); chk("R7 reset status", v, 16'h1000);
    rd(3'd6, v); chk("R11 reset mask", v, 0);
    chk("R8 reset irq empty", fifo_irq, 1);
    chk("R3 reset no load", dac_load, 0);

    // Configuration readback, polarity/reference stored only
    wr(3'd2, 16'h0139);
    rd(3'd2, v); chk("R9 R12 ctrl readback", v, 16'h1139);
    wr(3'd6, 16'h000B);
    rd(3'd6, v); chk("R11 mask readback", v, 16'h000B);

    for (int i = 0; i < 6; i++) wr(3'd0, 16'hA000 + 16'(i));
    rd(3'd2, v); chk("R7 fill 6 words", v, 16'h0139);

    // Trigger, then retrigger while busy, then status read while busy
    base = lcnt;
    @(negedge clk); bus_addr = 0; bus_rd = 1;
    @(negedge clk);
    @(negedge clk); bus_addr = 3'd2; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 0;
    chk("R4 busy during scan", v, 16'h8139);
    idle(6);
    chk("R4 retrigger ignored", lcnt - base, 3);
    chk("R3 chan0", ld_ch[base], 0);
    chk("R3 chan1", ld_ch[base+1], 1);
    chk("R3 chan3", ld_ch[base+2], 3);
    chk("R3 R12 code0", ld_code[base], 16'hA000);
    chk("R3 code1", ld_code[base+1], 16'hA001);
    chk("R3 code2", ld_code[base+2], 16'hA002);
    chk("R3 consecutive", ld_cyc[base+2] - ld_cyc[base], 2);

    base = lcnt;
    rd(3'd0, v); idle(6);
    chk("R3 second scan count", lcnt - base, 3);
    chk("R3 second scan code", ld_code[base+2], 16'hA005);
    rd(3'd2, v); chk("R7 empty after drain", v, 16'h1139);

    // Underrun
    wr(3'd0, 16'hC000); wr(3'd0, 16'hC001);
    base = lcnt;
    rd(3'd0, v); idle(5);
    chk("R5 underrun no load", lcnt - base, 0);
    rd(3'd2, v); chk("R5 underrun flag", v, 16'h0179);
    wr(3'd6, 16'h0003);
    rd(3'd0, v); idle(5);
    chk("R5 queue untouched count", lcnt - base, 2);
    chk("R5 queue untouched code", ld_code[base], 16'hC000);
    rd(3'd2, v); chk("R5 flag sticky", v, 16'h1179);
    wr(3'd2, 16'h1139);
    wr(3'd0, 16'h1234);
    rd(3'd2, v); chk("R9 fifo reset clears flag, bit12 not stored", v, 16'h0139);

    // Mask captured at trigger
    wr(3'd2, 16'h1139);
    wr(3'd0, 16'hD000); wr(3'd0, 16'hD001);
    base = lcnt;
    @(negedge clk); bus_addr = 0; bus_rd = 1;
    @(negedge clk); bus_rd = 0; bus_addr = 3'd6; bus_wdata = 16'h0001; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    idle(4);
    chk("R11 latched mask count", lcnt - base, 2);
    chk("R11 latched mask chan", ld_ch[base+1], 1);
    rd(3'd6, v); chk("R11 new mask stored", v, 1);

    // Disabled queue drops pushes
    wr(3'd2, 16'h1001);
    wr(3'd0, 16'h5555);
    wr(3'd2, 16'h0101);
    rd(3'd2, v); chk("R1 disabled push dropped", v, 16'h1101);

    // Fill/irq sweep over every count and select
    wr(3'd6, 16'h000F);
    for (int n = 0; n <= DEP; n++) begin
      for (int s = 0; s < 8; s++) begin
        wr(3'd2, 16'h0101 | 16'(s << 9));
        chk($sformatf("R8 irq sel%0d n%0d", s, n), fifo_irq, exp_irq(s, n));
      end
      wr(3'd2, 16'h0101);
      rd(3'd2, v);
      chk($sformatf("R7 fill n%0d", n), int'(v[14:12]), exp_fill(n));
      if (n < DEP) wr(3'd0, 16'hE000 + 16'(n));
    end
    wr(3'd0, 16'hEEEE);
    rd(3'd2, v); chk("R1 full push dropped", v, 16'h6101);
    base = lcnt;
    for (int t = 0; t < 4; t++) begin rd(3'd0, v); idle(6); end
    chk("R1 full drain count", lcnt - base, DEP);
    for (int i = 0; i < DEP; i++) begin
      chk($sformatf("R1 drain code %0d", i), ld_code[base+i], 16'hE000 + i);
      chk($sformatf("R3 drain chan %0d", i), ld_ch[base+i], i % 4);
    end

    // Recirculating mode
    wr(3'd2, 16'h1181);
    wr(3'd6, 16'h0001);
    for (int i = 0; i < 3; i++) wr(3'd0, 16'hF000 + 16'(i));
    base = lcnt;
    for (int t = 0; t < 7; t++) begin rd(3'd0, v); idle(3); end
    chk("R6 wrap load count", lcnt - base, 7);
    for (int i = 0; i < 7; i++)
      chk($sformatf("R6 wrap code %0d", i), ld_code[base+i], 16'hF000 + (i % 3));
    rd(3'd2, v); chk("R6 count kept", v, 16'h0181);

    // Trigger source matrix
    wr(3'd2, 16'h1100);
    for (int i = 0; i < 8; i++) wr(3'd0, 16'h9000 + 16'(i));
    for (int s = 0; s < 8; s++) begin
      wr(3'd2, 16'h0100 | 16'(s));
      for (int a = 0; a < 6; a++) begin
        int want;
        base = lcnt;
        case (a)
          0: rd(3'd0, v);
          1: begin @(negedge clk); ext_trig = 1; end
          2: begin @(negedge clk); ext_trig = 0; end
          default: begin
            @(negedge clk); pacer_out[a-3] = 1;
            @(negedge clk); pacer_out[a-3] = 0;
          end
        endcase
        idle(4);
        want = int'((s == 1 && a == 0) || (s == 2 && a == 1) || (s == 3 && a == 2) ||
                    (s >= 4 && s <= 6 && a == s - 1));
        chk($sformatf("R2 sel%0d action%0d", s, a), lcnt - base, want);
      end
    end

    // Global reset
    wr(3'd2, 16'h0101);
    wr(3'd6, 16'h0003);
    wr(3'd0, 16'h7777);
    wr(3'd2, 16'h21BF);
    rd(3'd2, v); chk("R10 global reset ctrl", v, 16'h1000);
    rd(3'd6, v); chk("R10 global reset mask", v, 0);
    chk("R10 irq after global reset", fifo_irq, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule